// File: doc/BRIEF.md
# SMBus Line Timeout and Hold Monitor

This block sits beside a two-wire SMBus controller and watches the clock and data lines. It raises a sticky flag when the clock line stays low longer than a programmed interval, which is 25 ms expressed in system-clock cycles. It also reports when the bus has been idle long enough to be considered free, meaning both lines have been high for more than a set number of periods of a slower clock-source tick.

A third stage holds back the controller's requested data-line value after each clock fall. The new value reaches the pad only after a short or a long fixed number of system clocks, chosen by an extended-timing select. Both line inputs pass through a two-flop synchronizer before any counting or edge detection takes place.

Top module: `smb_bus_watch`

## Requirements
- R1: During and right after reset, `low_timeout` and `bus_free` are 0 and `sda_drive` is 1 (released).
- R2: Line inputs take effect only after a two-flop synchronizer. A change on `scl_in` just after clock edge 0 is first acted on at edge 3.
- R3: With `low_to_en` set, `low_timeout` rises once the synchronized clock line has been sampled low for `LOW_LIMIT` consecutive cycles. For an `scl_in` fall just after edge 0, it is 0 after edge `LOW_LIMIT+1` and 1 after edge `LOW_LIMIT+2`.
- R4: The low-time count restarts from zero whenever the synchronized clock line is high, so low periods shorter than `LOW_LIMIT` never set the flag, however many occur.
- R5: `low_timeout` is sticky. It stays 1 after the clock line returns high, and it is cleared one edge after `low_to_clr` is 1 or after `low_to_en` is 0.
- R6: With `low_to_en` at 0, `low_timeout` stays 0 however long the clock line is low.
- R7: With `free_to_en` set and both lines high, `bus_free` becomes 1 on the edge that accepts the `FREE_TICKS+1`-th `src_tick` pulse. It is still 0 after `FREE_TICKS` pulses.
- R8: A low level on either synchronized line clears `bus_free` and restarts the tick count. After `sda_in` falls just after edge 0, `bus_free` is 1 after edge 2 and 0 after edge 3.
- R9: With `free_to_en` at 0, `bus_free` stays 0 whatever the lines and ticks do.
- R10: With `ext_timing` at 0, a falling synchronized clock line freezes `sda_drive` for a hold of 3 clocks. A request changed after the fall reaches `sda_drive` at edge 6, counted from an `scl_in` fall just after edge 0.
- R11: With `ext_timing` at 1, the hold is 12 clocks, and the pending request reaches `sda_drive` at edge 15 under the same counting.
- R12: Outside a hold window, `sda_drive` takes the value of `sda_req` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw clock-line level |
| sda_in | input | 1 | Raw data-line level |
| src_tick | input | 1 | One-cycle pulse per SMBus clock-source period |
| low_to_en | input | 1 | Enables clock-low timeout detection |
| low_to_clr | input | 1 | Clears the sticky timeout flag |
| free_to_en | input | 1 | Enables bus-free detection |
| ext_timing | input | 1 | Selects the long hold count |
| sda_req | input | 1 | Data-line value requested by the controller |
| low_timeout | output | 1 | Sticky clock-low timeout flag |
| bus_free | output | 1 | Bus idle-and-free indication |
| sda_drive | output | 1 | Hold-delayed data-line drive value |

## Verification
A stuck or mis-reloaded low-time counter shows up as `low_timeout` rising one or more edges away from edge `LOW_LIMIT+2`, or as the flag rising after a series of short low pulses. Either is visible within one timeout interval. A free-tick counter that is off by one moves the rise of `bus_free` by one tick pulse, and a missed restart lets `bus_free` come back before eleven new ticks. A wrong hold load or a wrong decrement moves the edge at which `sda_drive` changes, observable within 15 clocks of a clock-line fall.

// File: rtl/smb_watch_pkg.sv
// Package: shared types and helpers for the SMBus line monitor.
// Assumes: lines idle high; all counters count system-clock edges.
package smb_watch_pkg;

    // Synchronized view of both bus lines.
    typedef struct packed {
        logic scl;
        logic sda;
    } smb_lines_t;

    // Counter width able to hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Module: multi-stage synchronizer for the bus line inputs.
// Assumes: inputs are asynchronous; reset state is the idle-high level.
module smb_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop captures the raw level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= raw_i;
                end
            end else begin : g_next
                // Later flops resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/smb_low_timer.sv
// Module: clock-low timeout counter with sticky flag.
// Assumes: scl_s is synchronized; LIMIT >= 2. The count reloads to zero
// while SCL is high and saturates at LIMIT while SCL stays low.
module smb_low_timer
    import smb_watch_pkg::*;
#(
    parameter int LIMIT = 1_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic scl_s,
    output logic flag_o
);

    localparam int CW = cnt_width(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          hit;

    // Hit when this low cycle completes the programmed interval.
    assign hit = !scl_s && (cnt_q == CW'(LIMIT - 1));

    // Count low cycles, reload on high, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)          cnt_q <= '0;
        else if (scl_s)             cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flag: clear or disable wins, otherwise set on hit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) flag_o <= 1'b0;
        else if (hit)             flag_o <= 1'b1;
    end

endmodule

// File: rtl/smb_free_detect.sv
// Module: bus-free detector counting clock-source ticks while idle.
// Assumes: lines are synchronized; tick is a one-cycle pulse.
// Free is declared after more than TICKS ticks with both lines high.
module smb_free_detect
    import smb_watch_pkg::*;
#(
    parameter int TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  smb_lines_t lines,
    output logic       free_o
);

    localparam int FW = cnt_width(TICKS + 1);

    smb_lines_t    prev_q;
    logic [FW-1:0] cnt_q;
    logic          fall_any;
    logic          idle;

    assign fall_any = (prev_q.scl && !lines.scl) || (prev_q.sda && !lines.sda);
    assign idle     = lines.scl && lines.sda;

    // Remember last line levels for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= lines;
    end

    // Count ticks while idle; restart on any low or fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || fall_any || !idle) cnt_q <= '0;
        else if (tick && cnt_q != FW'(TICKS + 1)) cnt_q <= cnt_q + 1'b1;
    end

    // Free indication rises with the tick that exceeds TICKS.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || fall_any || !idle) free_o <= 1'b0;
        else if (tick && cnt_q == FW'(TICKS))    free_o <= 1'b1;
    end

endmodule

// File: rtl/smb_hold_delay.sv
// Module: SDA hold-delay stage.
// Assumes: scl_fall is a one-cycle pulse on a synchronized SCL fall.
// After a fall the drive is frozen for HOLD_SHORT or HOLD_LONG clocks,
// then picks up the current request; when idle it follows one cycle late.
module smb_hold_delay
    import smb_watch_pkg::*;
#(
    parameter int HOLD_SHORT = 3,
    parameter int HOLD_LONG  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_fall,
    input  logic ext,
    input  logic req,
    output logic drive_o,
    output logic busy_o
);

    localparam int HMAX = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
    localparam int HW   = cnt_width(HMAX);

    logic [HW-1:0] cnt_q;
    logic [HW-1:0] load_val;

    assign load_val = ext ? HW'(HOLD_LONG) : HW'(HOLD_SHORT);
    assign busy_o   = (cnt_q > HW'(1));

    // Hold counter: load on fall, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (scl_fall)     cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Drive register: frozen during hold, else takes the request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      drive_o <= 1'b1;
        else if (!scl_fall && !busy_o)   drive_o <= req;
    end

endmodule

// File: rtl/smb_bus_watch.sv
// Module: top of the SMBus line monitor.
// Synchronizes both lines, then feeds the clock-low timeout, the
// bus-free detector and the SDA hold-delay stage.
// Assumes: single clock domain; synchronous active-low reset.
module smb_bus_watch
    import smb_watch_pkg::*;
#(
    parameter int LOW_LIMIT   = 1_250_000,
    parameter int FREE_TICKS  = 10,
    parameter int HOLD_SHORT  = 3,
    parameter int HOLD_LONG   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic src_tick,
    input  logic low_to_en,
    input  logic low_to_clr,
    input  logic free_to_en,
    input  logic ext_timing,
    input  logic sda_req,
    output logic low_timeout,
    output logic bus_free,
    output logic sda_drive
);

    logic [1:0] sync_vec;
    smb_lines_t lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_prev_q;
    logic       scl_fall;
    logic       hold_busy;

    smb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in, sda_in}),
        .sync_o (sync_vec)
    );

    assign lines_s = smb_lines_t'(sync_vec);
    assign scl_s   = lines_s.scl;
    assign sda_s   = lines_s.sda;

    // Previous synchronized SCL for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_prev_q <= 1'b1;
        else        scl_prev_q <= scl_s;
    end

    assign scl_fall = scl_prev_q && !scl_s;

    smb_low_timer #(.LIMIT(LOW_LIMIT)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (low_to_en),
        .clr    (low_to_clr),
        .scl_s  (scl_s),
        .flag_o (low_timeout)
    );

    smb_free_detect #(.TICKS(FREE_TICKS)) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (free_to_en),
        .tick   (src_tick),
        .lines  (lines_s),
        .free_o (bus_free)
    );

    smb_hold_delay #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_fall (scl_fall),
        .ext      (ext_timing),
        .req      (sda_req),
        .drive_o  (sda_drive),
        .busy_o   (hold_busy)
    );

endmodule

// File: rtl/smb_bus_watch_chk.sv
// Checker: temporal properties of the SMBus line monitor, bound to the top.
module smb_bus_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic low_to_en,
    input logic low_to_clr,
    input logic free_to_en,
    input logic sda_req,
    input logic scl_s,
    input logic sda_s,
    input logic scl_fall,
    input logic hold_busy,
    input logic low_timeout,
    input logic bus_free,
    input logic sda_drive
);

    // R5: flag holds while enabled and not cleared.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_timeout && low_to_en && !low_to_clr) |=> low_timeout);

    // R5 / R6: clear or disable drops the flag.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_to_clr || !low_to_en) |=> !low_timeout);

    // R9: disabled free detection never reports free.
    p_free_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !free_to_en |=> !bus_free);

    // R8: a low line forbids free on the next cycle.
    p_line_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_s || !sda_s) |=> !bus_free);

    // R10: drive is frozen inside the hold window.
    p_hold_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_busy |=> $stable(sda_drive));

    // R12: outside the window the drive follows the request.
    p_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_busy && !scl_fall) |=> (sda_drive == $past(sda_req)));

endmodule

bind smb_bus_watch smb_bus_watch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .low_to_en   (low_to_en),
    .low_to_clr  (low_to_clr),
    .free_to_en  (free_to_en),
    .sda_req     (sda_req),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_fall    (scl_fall),
    .hold_busy   (hold_busy),
    .low_timeout (low_timeout),
    .bus_free    (bus_free),
    .sda_drive   (sda_drive)
);

// File: tb/smb_bus_watch_tb.sv
// Directed bench for the SMBus line monitor: one task per scenario.
module smb_bus_watch_tb_top;

    localparam int LIM   = 20;
    localparam int TICKS = 10;
    localparam int HS    = 3;
    localparam int HL    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, src_tick = 1'b0;
    logic low_to_en = 1'b0, low_to_clr = 1'b0, free_to_en = 1'b0;
    logic ext_timing = 1'b0, sda_req = 1'b1;
    logic low_timeout, bus_free, sda_drive;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smb_bus_watch #(
        .LOW_LIMIT(LIM), .FREE_TICKS(TICKS),
        .HOLD_SHORT(HS), .HOLD_LONG(HL), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .src_tick(src_tick), .low_to_en(low_to_en), .low_to_clr(low_to_clr),
        .free_to_en(free_to_en), .ext_timing(ext_timing), .sda_req(sda_req),
        .low_timeout(low_timeout), .bus_free(bus_free), .sda_drive(sda_drive)
    );

    // Advance n edges, then settle 1 ns past the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic pulse_tick();
        src_tick = 1'b1;
        step(1);
        src_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1 low_timeout in reset", low_timeout, 1'b0);
        chk("R1 bus_free in reset", bus_free, 1'b0);
        chk("R1 sda_drive in reset", sda_drive, 1'b1);
        rst_n = 1'b1;
        step(1);
        chk("R1 bus_free after reset", bus_free, 1'b0);
        chk("R1 low_timeout after reset", low_timeout, 1'b0);
    endtask

    task automatic t_low_fire();
        low_to_en = 1'b1;
        step(4);
        scl_in = 1'b0;
        step(LIM + 1);
        chk("R3 R2 flag not yet set", low_timeout, 1'b0);
        step(1);
        chk("R3 R2 flag set at limit", low_timeout, 1'b1);
    endtask

    task automatic t_low_sticky();
        scl_in = 1'b1;
        step(6);
        chk("R5 flag sticky after SCL high", low_timeout, 1'b1);
        low_to_clr = 1'b1;
        step(1);
        low_to_clr = 1'b0;
        chk("R5 flag cleared by clr", low_timeout, 1'b0);
        scl_in = 1'b0;
        step(LIM + 4);
        chk("R5 flag set again", low_timeout, 1'b1);
        scl_in = 1'b1;
        low_to_en = 1'b0;
        step(1);
        low_to_en = 1'b1;
        chk("R5 flag cleared by disable", low_timeout, 1'b0);
        step(4);
    endtask

    task automatic t_low_reload();
        for (int k = 0; k < 5; k++) begin
            scl_in = 1'b0;
            step(LIM - 1);
            scl_in = 1'b1;
            step(3);
        end
        chk("R4 short lows never flag", low_timeout, 1'b0);
    endtask

    task automatic t_low_disabled();
        low_to_en = 1'b0;
        scl_in = 1'b0;
        step(2 * LIM);
        chk("R6 disabled timeout stays low", low_timeout, 1'b0);
        scl_in = 1'b1;
        step(4);
    endtask

    task automatic t_free_detect();
        free_to_en = 1'b1;
        step(4);
        for (int k = 0; k < TICKS; k++) pulse_tick();
        chk("R7 not free after TICKS ticks", bus_free, 1'b0);
        pulse_tick();
        chk("R7 free after TICKS+1 ticks", bus_free, 1'b1);
    endtask

    task automatic t_free_drop();
        sda_in = 1'b0;
        step(2);
        chk("R8 free still set before sync", bus_free, 1'b1);
        step(1);
        chk("R8 free dropped by SDA low", bus_free, 1'b0);
        sda_in = 1'b1;
        step(4);
        for (int k = 0; k < TICKS; k++) pulse_tick();
        chk("R8 count restarted after low", bus_free, 1'b0);
        pulse_tick();
        chk("R8 free again after restart", bus_free, 1'b1);
    endtask

    task automatic t_free_disabled();
        free_to_en = 1'b0;
        step(1);
        for (int k = 0; k < 2 * TICKS; k++) pulse_tick();
        chk("R9 disabled never free", bus_free, 1'b0);
    endtask

    task automatic t_hold(input logic ext, input int h, input string tag);
        logic old_v;
        ext_timing = ext;
        step(4);
        old_v = sda_drive;
        scl_in = 1'b0;
        step(3);
        sda_req = ~old_v;
        chk({tag, " frozen at load"}, sda_drive, old_v);
        step(h - 1);
        chk({tag, " still held"}, sda_drive, old_v);
        step(1);
        chk({tag, " released"}, sda_drive, ~old_v);
        scl_in = 1'b1;
        step(4);
    endtask

    task automatic t_follow();
        ext_timing = 1'b0;
        step(4);
        sda_req = ~sda_drive;
        step(1);
        chk("R12 follows request", sda_drive, sda_req);
        sda_req = ~sda_req;
        step(1);
        chk("R12 follows back", sda_drive, sda_req);
    endtask

    initial begin
        t_reset();
        t_low_fire();
        t_low_sticky();
        t_low_reload();
        t_low_disabled();
        t_free_detect();
        t_free_drop();
        t_free_disabled();
        t_hold(1'b0, HS, "R10 short hold");
        t_hold(1'b1, HL, "R11 long hold");
        t_follow();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule